// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits beside a five-stage style CPU pipeline and turns exception requests into a controlled entry into the handler. Each cycle the pipeline presents a vector of request bits with some side information: the PC of the faulting instruction, a flag for a branch delay slot, the offending virtual address, a load/store flag and a coprocessor number. The unit picks the most urgent request by fixed priority. It then derives the 5-bit exception code and updates the machine-state registers (Status, Cause, EPC, BadVAddr and the exception base). One cycle after the request it drives a single-cycle redirect to the fetch stage that carries the handler address.

The handler address depends on the request class and on three state bits. These are the boot-vector select bit in Status, the exception-level bit in Status as it was before this entry, and the interrupt-vector select bit in Cause. Reset-class requests go to the boot address. TLB refills taken at exception level 0 go to the base itself. Interrupts may use a separate offset. Everything else uses the general offset. Software reaches the five registers through a simple select/write/read port whose read data comes back one cycle after the select.

Top module: `exc_vector_unit`

## Requirements
- R1: After the synchronous reset input, Status reads 0x2040_0000 (coprocessor-1 usable bit 29 and boot-vector bit 22 set, exception-level bit 1 clear), Cause, EPC and BadVAddr read 0, the exception base reads 0x8000_0000, and no redirect is driven.
- R2: Request bits are ranked by index, and bit 0 has the highest rank: 0 reset, 1 NMI, 2 fetch address error, 3 fetch TLB refill, 4 fetch TLB invalid, 5 coprocessor unusable, 6 reserved instruction, 7 syscall, 8 breakpoint, 9 overflow, 10 trap, 11 data address error, 12 data TLB refill, 13 data TLB invalid, 14 TLB modified, 15 interrupt. Only the winner has any effect.
- R3: A non-reset-class entry writes its code into Cause bits 6:2. The codes are interrupt 0, TLB modified 1, TLB refill/invalid 2 (load or fetch) or 3 (store), address error 4 (load or fetch) or 5 (store), syscall 8, breakpoint 9, reserved instruction 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD.
- R4: Each cycle with at least one request bit set produces a redirect valid pulse in the following cycle. A cycle with no request produces none.
- R5: Reset and NMI requests redirect to 0xBFC0_0000 and leave Cause, EPC and the exception-level bit unchanged. A reset request also sets Status bits 29 and 22.
- R6: With Status bit 22 set, every non-reset-class entry redirects to 0xBFC0_0200.
- R7: With Status bit 22 clear, a general entry redirects to base + 0x180.
- R8: With bit 22 clear, a TLB refill (index 3 or 12) redirects to base + 0 if Status bit 1 was 0 before the entry, and to base + 0x180 if it was already 1.
- R9: With bit 22 clear, an interrupt redirects to base + 0x200 when Cause bit 23 is 1, and to base + 0x180 otherwise.
- R10: A non-reset-class entry sets Status bit 1. If that bit was 0 before the entry, EPC takes the faulting PC (PC − 4 in a delay slot) and Cause bit 31 takes the delay-slot flag. If the bit was 1, both are left unchanged.
- R11: Address error and TLB entries (indices 2, 3, 4, 11, 12, 13, 14) load BadVAddr with the bad address. Every other entry leaves BadVAddr unchanged.
- R12: A coprocessor-unusable entry writes the coprocessor number into Cause bits 29:28. Other entries leave those bits unchanged.
- R13: The register port uses select 0 Status, 1 Cause, 2 EPC, 3 BadVAddr, 4 base. Status and EPC are fully writable. In Cause only bit 23 is writable. BadVAddr is read-only. The base keeps bits 31:12 and reads zero below them. Read data appears one cycle after the select. A write in a cycle that has any request bit set is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Exception request bits, ranked by index |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| in_delay_slot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| bad_addr_i | input | 32 | Offending virtual address |
| is_store_i | input | 1 | Data access was a store |
| cop_num_i | input | 2 | Coprocessor number for unusable faults |
| sw_we_i | input | 1 | Register write strobe |
| sw_sel_i | input | 3 | Register select |
| sw_wdata_i | input | 32 | Register write data |
| sw_rdata_o | output | 32 | Registered read data for the previous select |
| redir_valid_o | output | 1 | One-cycle redirect pulse |
| redir_pc_o | output | 32 | Handler address for the redirect |

## Verification
A request present at a clock edge updates every register and raises the redirect at that same edge, so the redirect and its address are due one cycle after the request is driven. The bench drives on the falling edge and samples at the next falling edge. Register contents then go through the read port. That adds one more edge, so a value read back reflects the entry two edges after the request. The bench waits that long before comparing. The same one-cycle spacing is used to confirm that the redirect drops in the cycle after an idle one.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN  = 32;
  localparam int NREQ  = 16;
  localparam int IDXW  = $clog2(NREQ);
  localparam int CODEW = 5;

  // request indices, lower index wins
  localparam int RQ_RESET   = 0;
  localparam int RQ_NMI     = 1;
  localparam int RQ_IADDR   = 2;
  localparam int RQ_IREFILL = 3;
  localparam int RQ_IINVAL  = 4;
  localparam int RQ_COPU    = 5;
  localparam int RQ_RSVD    = 6;
  localparam int RQ_SYS     = 7;
  localparam int RQ_BRK     = 8;
  localparam int RQ_OVF     = 9;
  localparam int RQ_TRAP    = 10;
  localparam int RQ_DADDR   = 11;
  localparam int RQ_DREFILL = 12;
  localparam int RQ_DINVAL  = 13;
  localparam int RQ_TMOD    = 14;
  localparam int RQ_INT     = 15;

  // state bit positions
  localparam int ST_CU1 = 29;
  localparam int ST_BEV = 22;
  localparam int ST_EXL = 1;
  localparam int CA_BD  = 31;
  localparam int CA_CE  = 28;
  localparam int CA_IV  = 23;
  localparam int CA_EC  = 2;

  // register select values
  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_BADVA  = 3'd3,
    SEL_BASE   = 3'd4
  } reg_sel_e;

  localparam logic [XLEN-1:0] BOOT_RESET_PC = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] BOOT_GEN_PC   = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] OFS_GENERAL   = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFS_IRQ       = 32'h0000_0200;
  localparam logic [XLEN-1:0] BASE_MASK     = 32'hFFFF_F000;
  localparam logic [XLEN-1:0] CAUSE_WMASK   = 32'h0080_0000;

  typedef struct packed {
    logic             boot_class;
    logic             load_badva;
    logic             set_ce;
    logic [CODEW-1:0] code;
  } entry_info_t;

  function automatic entry_info_t classify(input logic [IDXW-1:0] idx,
                                           input logic store);
    entry_info_t e;
    e = '0;
    case (int'(idx))
      RQ_RESET, RQ_NMI:      e.boot_class = 1'b1;
      RQ_IADDR:   begin e.code = 5'd4; e.load_badva = 1'b1; end
      RQ_IREFILL, RQ_IINVAL: begin e.code = 5'd2; e.load_badva = 1'b1; end
      RQ_COPU:    begin e.code = 5'hB; e.set_ce = 1'b1; end
      RQ_RSVD:    e.code = 5'hA;
      RQ_SYS:     e.code = 5'd8;
      RQ_BRK:     e.code = 5'd9;
      RQ_OVF:     e.code = 5'hC;
      RQ_TRAP:    e.code = 5'hD;
      RQ_DADDR:   begin e.code = store ? 5'd5 : 5'd4; e.load_badva = 1'b1; end
      RQ_DREFILL, RQ_DINVAL: begin e.code = store ? 5'd3 : 5'd2; e.load_badva = 1'b1; end
      RQ_TMOD:    begin e.code = 5'd1; e.load_badva = 1'b1; end
      default:    e.code = 5'd0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_pkg::*;
(
  input  logic [IDXW-1:0] win,
  input  logic            store,
  input  logic            bev,
  input  logic            exl_before,
  input  logic            iv,
  input  logic [XLEN-1:0] base,
  output entry_info_t     info,
  output logic [XLEN-1:0] target
);
  logic            is_refill;
  logic            is_irq;
  logic [XLEN-1:0] ofs;

  assign info      = classify(win, store);
  assign is_refill = (int'(win) == RQ_IREFILL) || (int'(win) == RQ_DREFILL);
  assign is_irq    = (int'(win) == RQ_INT);

  always_comb begin
    if (is_refill && !exl_before) ofs = '0;
    else if (is_irq && iv)        ofs = OFS_IRQ;
    else                          ofs = OFS_GENERAL;
  end

  always_comb begin
    if (info.boot_class) target = BOOT_RESET_PC;
    else if (bev)        target = BOOT_GEN_PC;
    else                 target = base + ofs;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] BASE_RESET = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            take_reset,
  input  entry_info_t     info,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] fault_pc,
  input  logic            in_ds,
  input  logic [XLEN-1:0] bad_addr,
  input  logic [1:0]      cop_num,
  input  logic            sw_we,
  input  logic [2:0]      sw_sel,
  input  logic [XLEN-1:0] sw_wdata,
  output logic [XLEN-1:0] sw_rdata,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badva_q,
  output logic [XLEN-1:0] base_q,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);
  localparam logic [XLEN-1:0] STATUS_RESET =
    (XLEN'(1) << ST_CU1) | (XLEN'(1) << ST_BEV);

  logic            sw_ok;
  logic [XLEN-1:0] epc_new;

  assign sw_ok   = sw_we && !take;
  assign epc_new = in_ds ? fault_pc - XLEN'(4) : fault_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q    <= STATUS_RESET;
      cause_q     <= '0;
      epc_q       <= '0;
      badva_q     <= '0;
      base_q      <= BASE_RESET & BASE_MASK;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      sw_rdata    <= '0;
    end else begin
      redir_valid <= take;
      if (take) redir_pc <= target;

      case (reg_sel_e'(sw_sel))
        SEL_STATUS: sw_rdata <= status_q;
        SEL_CAUSE:  sw_rdata <= cause_q;
        SEL_EPC:    sw_rdata <= epc_q;
        SEL_BADVA:  sw_rdata <= badva_q;
        SEL_BASE:   sw_rdata <= base_q;
        default:    sw_rdata <= '0;
      endcase

      if (take && take_reset) begin
        status_q[ST_CU1] <= 1'b1;
        status_q[ST_BEV] <= 1'b1;
      end else if (take && !info.boot_class) begin
        status_q[ST_EXL]               <= 1'b1;
        cause_q[CA_EC +: CODEW]        <= info.code;
        if (!status_q[ST_EXL]) begin
          epc_q          <= epc_new;
          cause_q[CA_BD] <= in_ds;
        end
        if (info.load_badva) badva_q <= bad_addr;
        if (info.set_ce)     cause_q[CA_CE +: 2] <= cop_num;
      end else if (sw_ok) begin
        case (reg_sel_e'(sw_sel))
          SEL_STATUS: status_q <= sw_wdata;
          SEL_CAUSE:  cause_q  <= (cause_q & ~CAUSE_WMASK) | (sw_wdata & CAUSE_WMASK);
          SEL_EPC:    epc_q    <= sw_wdata;
          SEL_BASE:   base_q   <= sw_wdata & BASE_MASK;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] BASE_RESET = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] req_i,
  input  logic [31:0] fault_pc_i,
  input  logic        in_delay_slot_i,
  input  logic [31:0] bad_addr_i,
  input  logic        is_store_i,
  input  logic [1:0]  cop_num_i,
  input  logic        sw_we_i,
  input  logic [2:0]  sw_sel_i,
  input  logic [31:0] sw_wdata_i,
  output logic [31:0] sw_rdata_o,
  output logic        redir_valid_o,
  output logic [31:0] redir_pc_o
);
  logic            any_req;
  logic [IDXW-1:0] win;
  entry_info_t     info;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] status_w, cause_w, epc_w, badva_w, base_w;

  exc_prio_sel #(.N(NREQ)) u_prio (
    .req (req_i),
    .any (any_req),
    .win (win)
  );

  exc_vec_calc u_vec (
    .win        (win),
    .store      (is_store_i),
    .bev        (status_w[ST_BEV]),
    .exl_before (status_w[ST_EXL]),
    .iv         (cause_w[CA_IV]),
    .base       (base_w),
    .info       (info),
    .target     (target)
  );

  exc_state_regs #(.BASE_RESET(BASE_RESET)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .take        (any_req),
    .take_reset  (int'(win) == RQ_RESET),
    .info        (info),
    .target      (target),
    .fault_pc    (fault_pc_i),
    .in_ds       (in_delay_slot_i),
    .bad_addr    (bad_addr_i),
    .cop_num     (cop_num_i),
    .sw_we       (sw_we_i),
    .sw_sel      (sw_sel_i),
    .sw_wdata    (sw_wdata_i),
    .sw_rdata    (sw_rdata_o),
    .status_q    (status_w),
    .cause_q     (cause_w),
    .epc_q       (epc_w),
    .badva_q     (badva_w),
    .base_q      (base_w),
    .redir_valid (redir_valid_o),
    .redir_pc    (redir_pc_o)
  );
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] req_i,
  input logic        redir_valid_o,
  input logic [31:0] redir_pc_o,
  input logic [31:0] status_w,
  input logic [31:0] epc_w
);
  logic boot_req;
  logic gen_req;
  assign boot_req = req_i[0] | req_i[1];
  assign gen_req  = (|req_i[15:2]) && !boot_req;

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |=> redir_valid_o);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|req_i) |=> !redir_valid_o);

  // R5
  boot_target_chk: assert property (@(posedge clk) disable iff (rst)
    boot_req |=> (redir_pc_o == 32'hBFC0_0000));

  // R6
  bev_target_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_req && status_w[22]) |=> (redir_pc_o == 32'hBFC0_0200));

  // R10
  exl_set_chk: assert property (@(posedge clk) disable iff (rst)
    gen_req |=> status_w[1]);

  // R10
  epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_req && status_w[1]) |=> $stable(epc_w));
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .redir_valid_o (redir_valid_o),
  .redir_pc_o    (redir_pc_o),
  .status_w      (status_w),
  .epc_w         (epc_w)
);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic [31:0] fpc = '0;
  logic        ds = 1'b0;
  logic [31:0] bva = '0;
  logic        st = 1'b0;
  logic [1:0]  cop = '0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rv;
  logic [31:0] rpc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit u_dut (
    .clk(clk), .rst(rst), .req_i(req), .fault_pc_i(fpc),
    .in_delay_slot_i(ds), .bad_addr_i(bva), .is_store_i(st),
    .cop_num_i(cop), .sw_we_i(we), .sw_sel_i(sel), .sw_wdata_i(wdata),
    .sw_rdata_o(rdata), .redir_valid_o(rv), .redir_pc_o(rpc)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    @(negedge clk);
    d = rdata;
  endtask

  // drive one request cycle, check the redirect and its drop (R4)
  task automatic fire(input string tag, input logic [15:0] r, input logic [31:0] pc,
                      input logic dsl, input logic [31:0] ba, input logic s,
                      input logic [1:0] c, input logic [31:0] exp_pc);
    @(negedge clk);
    req = r; fpc = pc; ds = dsl; bva = ba; st = s; cop = c;
    @(negedge clk);
    req = '0;
    chk({tag, " R4 pulse"}, {31'd0, rv}, 32'd1);
    chk({tag, " target"}, rpc, exp_pc);
    @(negedge clk);
    chk({tag, " R4 drop"}, {31'd0, rv}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 no redirect", {31'd0, rv}, 32'd0);
    rd(3'd0, v); chk("R1 status", v, 32'h2040_0000);
    rd(3'd1, v); chk("R1 cause", v, 32'h0);
    rd(3'd2, v); chk("R1 epc", v, 32'h0);
    rd(3'd3, v); chk("R1 badva", v, 32'h0);
    rd(3'd4, v); chk("R1 base", v, 32'h8000_0000);
  endtask

  task automatic t_boot_vector;
    logic [31:0] v;
    fire("R6 syscall bev", 16'h0080, 32'h1000, 1'b0, 32'h0, 1'b0, 2'd0, 32'hBFC0_0200);
    rd(3'd1, v); chk("R3 syscall code", {27'd0, v[6:2]}, 32'd8);
    rd(3'd2, v); chk("R10 epc", v, 32'h1000);
    rd(3'd0, v); chk("R10 exl set", v, 32'h2040_0002);
  endtask

  task automatic t_config;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h8000_1ABC);
    rd(3'd4, v); chk("R13 base mask", v, 32'h8000_1000);
    wr(3'd3, 32'h5555_5555);
    rd(3'd3, v); chk("R13 badva read-only", v, 32'h0);
  endtask

  task automatic t_delay_slot;
    logic [31:0] v;
    fire("R7 overflow", 16'h0200, 32'h0040_0100, 1'b1, 32'h0, 1'b0, 2'd0, 32'h8000_1180);
    rd(3'd2, v); chk("R10 epc ds", v, 32'h0040_00FC);
    rd(3'd1, v); chk("R10 cause bd code", v, 32'h8000_0030);
  endtask

  task automatic t_nested;
    logic [31:0] v;
    fire("R8 refill exl1", 16'h1000, 32'h0050_0000, 1'b0, 32'h1234_5678, 1'b1, 2'd0, 32'h8000_1180);
    rd(3'd2, v); chk("R10 epc kept", v, 32'h0040_00FC);
    rd(3'd1, v); chk("R10 bd kept, R3 code 3", v, 32'h8000_000C);
    rd(3'd3, v); chk("R11 badva", v, 32'h1234_5678);
    wr(3'd0, 32'h0);
    fire("R8 refill exl0", 16'h1000, 32'h0060_0000, 1'b0, 32'hCAFE_0000, 1'b0, 2'd0, 32'h8000_1000);
    rd(3'd1, v); chk("R3 refill load code", {27'd0, v[6:2]}, 32'd2);
    rd(3'd3, v); chk("R11 badva refill", v, 32'hCAFE_0000);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    fire("R2 copu wins", 16'h8220, 32'h700, 1'b0, 32'h0, 1'b0, 2'd2, 32'h8000_1180);
    rd(3'd1, v); chk("R2 copu code", {27'd0, v[6:2]}, 32'hB);
    chk("R12 ce", {30'd0, v[29:28]}, 32'd2);
    wr(3'd0, 32'h0);
    fire("R2 iaddr wins", 16'h008C, 32'h800, 1'b0, 32'hDEAD_0004, 1'b0, 2'd1, 32'h8000_1180);
    rd(3'd1, v); chk("R2 iaddr code", {27'd0, v[6:2]}, 32'd4);
    chk("R12 ce kept", {30'd0, v[29:28]}, 32'd2);
    rd(3'd3, v); chk("R11 iaddr badva", v, 32'hDEAD_0004);
    wr(3'd0, 32'h0);
    fire("R11 syscall", 16'h0080, 32'h900, 1'b0, 32'h1111_1111, 1'b0, 2'd0, 32'h8000_1180);
    rd(3'd3, v); chk("R11 badva unchanged", v, 32'hDEAD_0004);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R13 cause only iv", v[23] && v[6:2] == 5'd8 ? 32'd1 : 32'd0, 32'd1);
    fire("R9 irq iv1", 16'h8000, 32'hA00, 1'b0, 32'h0, 1'b0, 2'd0, 32'h8000_1200);
    rd(3'd1, v); chk("R3 irq code", {27'd0, v[6:2]}, 32'd0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    fire("R9 irq iv0", 16'h8000, 32'hB00, 1'b0, 32'h0, 1'b0, 2'd0, 32'h8000_1180);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    req = 16'h0080; we = 1'b1; sel = 3'd4; wdata = 32'h9000_0000;
    @(negedge clk);
    req = '0; we = 1'b0;
    chk("R13 collide pulse", {31'd0, rv}, 32'd1);
    rd(3'd4, v); chk("R13 write dropped", v, 32'h8000_1000);
  endtask

  task automatic t_boot_class;
    logic [31:0] v, e0, c0;
    rd(3'd2, e0);
    rd(3'd1, c0);
    wr(3'd0, 32'h0);
    fire("R5 reset req", 16'h0021, 32'hC00, 1'b1, 32'h0, 1'b0, 2'd3, 32'hBFC0_0000);
    rd(3'd0, v); chk("R5 status cu1 bev", v, 32'h2040_0000);
    rd(3'd2, v); chk("R5 epc kept", v, e0);
    rd(3'd1, v); chk("R5 cause kept", v, c0);
    fire("R5 nmi", 16'h0002, 32'hD00, 1'b0, 32'h0, 1'b0, 2'd0, 32'hBFC0_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_boot_vector();
    t_config();
    t_delay_slot();
    t_nested();
    t_priority();
    t_irq();
    t_collide();
    t_boot_class();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule